// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor request port and a slower memory port that is addressed by word. It holds 1024 one-word lines. Each line keeps a valid flag, a 20-bit tag and one 32-bit data word. A processor read that hits is answered from the line. A read that misses first lets every queued write reach memory. It then fetches the word, installs it in the line and returns it.

Every processor write is sent to memory through a four-entry posted FIFO, so a write costs the processor one accepted cycle unless the FIFO is full. A write that hits also refreshes the cached word in the same cycle. A write that misses leaves the cache untouched, because there is no write-allocate. Memory writes come only from that FIFO, so a read miss never causes one. The request sides of both ports use a valid/ready handshake. The processor accepts a read response as a one-cycle pulse, and the memory returns read data as a one-cycle pulse.

Top module: `wt_cache`

## Requirements
- R1: A byte address splits into tag = addr[31:12], line index = addr[11:2] and byte offset = addr[1:0]. The offset plays no part in lookup. The memory port carries the word address addr[31:2].
- R2: A read hits only when the indexed line is valid and its tag equals the address tag. A hit raises the read response one cycle after acceptance, carrying the cached word, and issues no memory request.
- R3: On a read miss the block issues one memory read of the word address. It writes the returned word and tag into the line and presents the word on the response one cycle after the memory response pulse.
- R4: Each accepted write reaches the memory port as exactly one write, with the same word address and data, in the order in which the writes were accepted.
- R5: A write that hits updates the cached word, so a later read of that address hits and returns the new data.
- R6: A write that misses does not fill a line, so a later read of that address is a miss.
- R7: The write FIFO holds 4 entries. A write is accepted in the cycle it is presented while fewer than 4 are pending, even when memory is not ready. With 4 pending, the write request is held off.
- R8: A read miss issues its memory read only after the write FIFO is empty, and no memory write occurs while that read is outstanding. A read therefore always returns the most recently written data.
- R9: After reset no line is valid. The first read of any address misses, no memory request is active and no response is pending.
- R10: While a read miss is outstanding the processor request port is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid is high |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | One-cycle read response pulse |
| cpu_rsp_rdata | output | 32 | Read response data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 30 | Word address |
| mem_req_wdata | output | 32 | Write data to memory |
| mem_rsp_valid | input | 1 | One-cycle read data pulse from memory |
| mem_rsp_rdata | input | 32 | Read data from memory |

## Verification
Directed sequences come first. A cold read and its repeat separate the miss path from the hit path. A write hit followed by a read shows the line was refreshed, while a write miss followed by a read shows that no allocation took place. Two addresses that share an index but differ in tag show eviction, and a read that differs only in its byte offset shows that the offset is ignored. Stopping the memory while five writes are issued exposes the FIFO limit and the stall on the fifth write. A long mixed run follows, with reads and writes over a few tags and indexes and a memory that stalls from time to time. It is compared each cycle against a behavioural model of memory order and line contents, so stale data or a read that overtakes a queued write is caught.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int OFF_W   = 2;
  localparam int WADDR_W = ADDR_W - OFF_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_FETCH,
    ST_WAIT
  } ctrl_state_e;

  typedef struct packed {
    logic [WADDR_W-1:0] waddr;
    logic [DATA_W-1:0]  data;
  } wb_entry_t;

  function automatic logic [WADDR_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction
endpackage

// File: rtl/wt_line_store.sv
module wt_line_store #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/wt_post_fifo.sv
module wt_post_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 62,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      unique case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = slot_q[rd_ptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign count = cnt_q;
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wt_cache_pkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int WB_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  output logic               cpu_req_ready,
  input  logic               cpu_req_we,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic [DATA_W-1:0]  cpu_req_wdata,
  output logic               cpu_rsp_valid,
  output logic [DATA_W-1:0]  cpu_rsp_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_we,
  output logic [WADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [DATA_W-1:0]  mem_rsp_rdata
);
  localparam int TAG_W = WADDR_W - IDX_W;
  localparam int ENT_W = $bits(wb_entry_t);
  localparam int CNT_W = $clog2(WB_DEPTH + 1);

  function automatic logic [IDX_W-1:0] idx_of(input logic [WADDR_W-1:0] wa);
    return wa[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [WADDR_W-1:0] wa);
    return wa[WADDR_W-1:IDX_W];
  endfunction

  ctrl_state_e        state_q;
  logic [WADDR_W-1:0] miss_waddr_q;
  logic [WADDR_W-1:0] look_waddr;
  logic               line_valid;
  logic [TAG_W-1:0]   line_tag;
  logic [DATA_W-1:0]  line_data;
  logic               lookup_hit;

  // named events used by the controller and the checker
  logic cpu_fire, rd_fire, wr_fire;
  logic rd_hit_ev, rd_miss_ev, wr_hit_ev, fill_ev;
  logic fetch_busy;

  logic               wb_empty, wb_full, wb_pop;
  logic [CNT_W-1:0]   wb_count;
  logic [ENT_W-1:0]   wb_head_bits;
  wb_entry_t          wb_head, wb_new;
  logic               drain_req;

  logic               line_we;
  logic [DATA_W-1:0]  line_wdata;
  logic               unused_off;

  assign unused_off = ^cpu_req_addr[OFF_W-1:0];

  assign look_waddr = (state_q == ST_IDLE) ? word_of(cpu_req_addr) : miss_waddr_q;
  assign lookup_hit = line_valid && (line_tag == tag_of(look_waddr));

  assign cpu_req_ready = (state_q == ST_IDLE) && !(cpu_req_we && wb_full);
  assign cpu_fire   = cpu_req_valid && cpu_req_ready;
  assign rd_fire    = cpu_fire && !cpu_req_we;
  assign wr_fire    = cpu_fire && cpu_req_we;
  assign rd_hit_ev  = rd_fire && lookup_hit;
  assign rd_miss_ev = rd_fire && !lookup_hit;
  assign wr_hit_ev  = wr_fire && lookup_hit;
  assign fill_ev    = (state_q == ST_WAIT) && mem_rsp_valid;
  assign fetch_busy = (state_q == ST_FETCH) || (state_q == ST_WAIT);

  assign line_we    = wr_hit_ev || fill_ev;
  assign line_wdata = fill_ev ? mem_rsp_rdata : cpu_req_wdata;

  wt_line_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (idx_of(look_waddr)),
    .rd_valid(line_valid),
    .rd_tag  (line_tag),
    .rd_data (line_data),
    .wr_en   (line_we),
    .wr_idx  (idx_of(look_waddr)),
    .wr_tag  (tag_of(look_waddr)),
    .wr_data (line_wdata)
  );

  assign wb_new  = '{waddr: word_of(cpu_req_addr), data: cpu_req_wdata};
  assign wb_head = wb_entry_t'(wb_head_bits);

  wt_post_fifo #(
    .DEPTH(WB_DEPTH),
    .W    (ENT_W)
  ) u_wbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wr_fire),
    .push_data(wb_new),
    .pop      (wb_pop),
    .head     (wb_head_bits),
    .empty    (wb_empty),
    .full     (wb_full),
    .count    (wb_count)
  );

  // memory port: buffered writes first, the fetch only once they are gone
  assign drain_req     = !wb_empty;
  assign wb_pop        = drain_req && mem_req_ready;
  assign mem_req_valid = drain_req || (state_q == ST_FETCH);
  assign mem_req_we    = drain_req;
  assign mem_req_addr  = drain_req ? wb_head.waddr : miss_waddr_q;
  assign mem_req_wdata = wb_head.data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      miss_waddr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rd_miss_ev) begin
          state_q      <= ST_DRAIN;
          miss_waddr_q <= look_waddr;
        end
        ST_DRAIN: if (wb_empty) state_q <= ST_FETCH;
        ST_FETCH: if (mem_req_ready && !drain_req) state_q <= ST_WAIT;
        ST_WAIT:  if (mem_rsp_valid) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      cpu_rsp_valid <= rd_hit_ev || fill_ev;
      if (rd_hit_ev)    cpu_rsp_rdata <= line_data;
      else if (fill_ev) cpu_rsp_rdata <= mem_rsp_rdata;
    end
  end
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int WB_DEPTH = 4,
  parameter int CNT_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_fire,
  input logic             rd_hit_ev,
  input logic             fetch_busy,
  input logic             wb_full,
  input logic             wb_empty,
  input logic [CNT_W-1:0] wb_count,
  input logic             cpu_req_ready,
  input logic             cpu_rsp_valid,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_we
);
  // R7: a write is never pushed into a full buffer
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !wb_full);

  // R7: occupancy stays within the buffer depth
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_count <= CNT_W'(WB_DEPTH));

  // R8: a memory read only leaves with the buffer empty
  p_fetch_after_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we) |-> wb_empty);

  // R8: no memory write while a fetch is outstanding
  p_quiet_during_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_busy |-> !(mem_req_valid && mem_req_we));

  // R2: a hit is answered in the next cycle
  p_hit_reply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_ev |=> cpu_rsp_valid);

  // R10: processor port held off during a miss
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_busy |-> !cpu_req_ready);

  // R3: a memory request, once raised, stays until taken
  p_mem_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);
endmodule

bind wt_cache wt_cache_chk #(
  .WB_DEPTH(WB_DEPTH),
  .CNT_W   (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_fire      (wr_fire),
  .rd_hit_ev    (rd_hit_ev),
  .fetch_busy   (fetch_busy),
  .wb_full      (wb_full),
  .wb_empty     (wb_empty),
  .wb_count     (wb_count),
  .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_we   (mem_req_we)
);

// File: tb/tb_wt_cache.sv
module tb_wt_cache;
  localparam int MEM_LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [29:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  always #10 clk = ~clk;

  wt_cache dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int checks = 0, errors = 0, cyc = 0;
  int mem_mode = 0;

  logic [31:0] prog_img [int];
  logic [31:0] mem_img  [int];
  bit          ref_v    [int];
  logic [19:0] ref_t    [int];

  typedef struct { logic [29:0] a; logic [31:0] d; } wr_t;
  typedef struct { int due; logic [31:0] d; bit hit; } exp_t;
  typedef struct { int due; logic [31:0] d; } mrsp_t;
  wr_t   wq[$];
  exp_t  eq[$];
  mrsp_t mrq[$];

  bit          miss_pending = 0, miss_issued = 0;
  logic [29:0] miss_waddr = '0;
  bit          pend_valid = 0, pend_we = 0, accepted = 0;
  logic [31:0] pend_addr = '0, pend_wdata = '0;
  bit          last_hit = 0;

  function automatic logic [31:0] init_word(input int wa);
    return (wa * 32'h9E37_79B1) ^ 32'h3C3C_0F0F;
  endfunction
  function automatic logic [31:0] prog_rd(input int wa);
    return prog_img.exists(wa) ? prog_img[wa] : init_word(wa);
  endfunction
  function automatic logic [31:0] mem_rd(input int wa);
    return mem_img.exists(wa) ? mem_img[wa] : init_word(wa);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    int idx, wa;
    logic [19:0] tg;
    @(negedge clk);
    cpu_req_valid = pend_valid;
    cpu_req_we    = pend_we;
    cpu_req_addr  = pend_addr;
    cpu_req_wdata = pend_wdata;
    case (mem_mode)
      0:       mem_req_ready = 1'b1;
      1:       mem_req_ready = (cyc % 3) != 1;
      default: mem_req_ready = 1'b0;
    endcase
    mem_rsp_valid = 1'b0;
    if (mrq.size() > 0 && mrq[0].due == cyc) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_rdata = mrq[0].d;
      void'(mrq.pop_front());
      if (eq.size() > 0) eq[0].due = cyc + 1;
    end
    #1;
    // read responses (R2 hits, R3 misses)
    if (cpu_rsp_valid) begin
      if (eq.size() == 0) check(0, "R2", "unexpected response", cpu_rsp_rdata, 32'h0);
      else begin
        check(eq[0].due == cyc, eq[0].hit ? "R2" : "R3", "response cycle", cyc, eq[0].due);
        check(cpu_rsp_rdata == eq[0].d, eq[0].hit ? "R2" : "R8", "read data", cpu_rsp_rdata, eq[0].d);
        if (!eq[0].hit) miss_pending = 0;
        void'(eq.pop_front());
      end
    end else if (eq.size() > 0 && eq[0].due == cyc) begin
      check(0, eq[0].hit ? "R2" : "R3", "missing response", 32'h0, 32'h1);
      if (!eq[0].hit) miss_pending = 0;
      void'(eq.pop_front());
    end
    if (miss_pending) check(!cpu_req_ready, "R10", "ready during miss", cpu_req_ready, 32'h0);
    // memory handshake
    if (mem_req_valid && mem_req_ready) begin
      wa = int'(mem_req_addr);
      if (mem_req_we) begin
        if (wq.size() == 0) check(0, "R4", "extra memory write", mem_req_addr, 32'h0);
        else begin
          check(mem_req_addr == wq[0].a, "R4", "write address", mem_req_addr, wq[0].a);
          check(mem_req_wdata == wq[0].d, "R4", "write data", mem_req_wdata, wq[0].d);
          void'(wq.pop_front());
        end
        mem_img[wa] = mem_req_wdata;
      end else begin
        check(miss_pending && !miss_issued, "R2", "memory read without a miss", mem_req_addr, miss_waddr);
        check(wq.size() == 0, "R8", "fetch before drain", wq.size(), 32'h0);
        check(mem_req_addr == miss_waddr, "R3", "fetch address", mem_req_addr, miss_waddr);
        miss_issued = 1;
        mrq.push_back('{due: cyc + MEM_LAT, d: mem_rd(wa)});
      end
    end
    // processor handshake
    if (cpu_req_valid && cpu_req_ready) begin
      wa  = int'(cpu_req_addr[31:2]);   // R1 word address
      idx = int'(cpu_req_addr[11:2]);   // R1 index
      tg  = cpu_req_addr[31:12];        // R1 tag
      if (cpu_req_we) begin
        wq.push_back('{a: cpu_req_addr[31:2], d: cpu_req_wdata});
        prog_img[wa] = cpu_req_wdata;
      end else begin
        last_hit = ref_v.exists(idx) && ref_t[idx] == tg;
        if (last_hit) eq.push_back('{due: cyc + 1, d: prog_rd(wa), hit: 1'b1});
        else begin
          eq.push_back('{due: -1, d: prog_rd(wa), hit: 1'b0});
          ref_v[idx] = 1;
          ref_t[idx] = tg;
          miss_pending = 1;
          miss_issued  = 0;
          miss_waddr   = cpu_req_addr[31:2];
        end
      end
      pend_valid = 0;
      accepted   = 1;
    end
    cyc++;
  endtask

  task automatic do_op(input bit we, input logic [31:0] a, input logic [31:0] d, output int n);
    pend_valid = 1; pend_we = we; pend_addr = a; pend_wdata = d;
    accepted = 0; n = 0;
    while (!accepted && n < 2000) begin tick(); n++; end
    if (!accepted) begin
      check(0, we ? "R7" : "R10", "request never accepted", a, 32'h0);
      pend_valid = 0;
    end
  endtask

  task automatic settle();
    int n = 0;
    while ((eq.size() > 0 || wq.size() > 0 || miss_pending) && n < 2000) begin tick(); n++; end
    check(n < 2000, "R4", "drain timeout", n, 32'h0);
    tick();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    logic [31:0] a_addr, b_addr, c_addr, lfsr, ad;
    a_addr = 32'h0001_2344;
    b_addr = 32'h0003_4568;
    c_addr = a_addr ^ 32'h0040_0000;  // same index, other tag
    repeat (3) tick();
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R9: reset state
    check(cpu_req_ready == 1'b1, "R9", "ready after reset", cpu_req_ready, 32'h1);
    check(mem_req_valid == 1'b0, "R9", "no memory request", mem_req_valid, 32'h0);
    check(cpu_rsp_valid == 1'b0, "R9", "no response", cpu_rsp_valid, 32'h0);

    // R9/R3: cold read misses; R2: the repeat hits
    do_op(0, a_addr, 0, n);
    check(!last_hit, "R9", "cold read is a miss", last_hit, 32'h0);
    settle();
    do_op(0, a_addr, 0, n);
    check(last_hit, "R2", "repeat read hits", last_hit, 32'h1);
    settle();
    // R1: byte offset ignored
    do_op(0, a_addr + 32'd3, 0, n);
    check(last_hit, "R1", "offset does not matter", last_hit, 32'h1);
    settle();
    // R5: write hit refreshes line
    do_op(1, a_addr, 32'hCAFE_0001, n);
    do_op(0, a_addr, 0, n);
    check(last_hit, "R5", "read after write hit hits", last_hit, 32'h1);
    settle();
    // R6: write miss does not allocate; R8: read sees the queued value
    mem_mode = 2;
    do_op(1, b_addr, 32'hBEEF_0002, n);
    mem_mode = 1;
    do_op(0, b_addr, 0, n);
    check(!last_hit, "R6", "read after write miss misses", last_hit, 32'h0);
    settle();
    mem_mode = 0;
    // R1: conflicting tag evicts
    do_op(0, c_addr, 0, n);
    do_op(0, a_addr, 0, n);
    check(!last_hit, "R1", "evicted line misses", last_hit, 32'h0);
    settle();

    // R7: four writes accepted at once with memory stalled, fifth held
    mem_mode = 2;
    for (int i = 0; i < 4; i++) begin
      do_op(1, 32'h0100_0000 + 32'(i * 4), 32'h7700_0000 + 32'(i), n);
      check(n == 1, "R7", "write accepted without waiting", n, 32'h1);
    end
    pend_valid = 1; pend_we = 1; pend_addr = 32'h0100_0010; pend_wdata = 32'h7700_0004;
    accepted = 0;
    repeat (3) tick();
    check(!accepted && !cpu_req_ready, "R7", "fifth write held off", cpu_req_ready, 32'h0);
    mem_mode = 0;
    n = 0;
    while (!accepted && n < 100) begin tick(); n++; end
    check(accepted, "R7", "fifth write accepted after drain", accepted, 32'h1);
    do_op(0, 32'h0100_000C, 0, n);
    settle();

    // mixed traffic against the model
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      mem_mode = (i / 40) % 2;
      ad = {18'h0, lfsr[5:4], 7'h0, lfsr[8:6], lfsr[10:9]};
      do_op(lfsr[12], ad, lfsr ^ 32'h5555_AAAA, n);
      if (lfsr[15:13] == 3'd0) settle();
    end
    mem_mode = 0;
    settle();
    summary();
    $finish;
  end
endmodule